// File: doc/BRIEF.md
# Instruction Prefix and Register-Index Extender

This block sits beside the operand decoder of a small processor. Software writes a 16-bit prefix word together with a 3-bit bank index. For exactly one following instruction, the block then does two things. It supplies the low byte of that word as the high byte of the instruction's immediate operand. It also widens the instruction's raw 4-bit source field and raw 3-bit destination field into 5-bit addresses, which reach a 32-entry register space. When that instruction retires, the word and the index fall back to zero. Sources then map to 00h–0Fh and destinations to 00h–07h.

The control is a two-state machine. In `PS_IDLE` no prefix is held, and the outputs carry the default mapping. In `PS_ARMED` a prefix word and index are held and drive the outputs. There are four transitions:

- **load**: from `PS_IDLE` to `PS_ARMED` on a prefix write.
- **reload**: from `PS_ARMED` to `PS_ARMED` on a prefix write, including one that arrives together with the advance strobe.
- **retire**: from `PS_ARMED` to `PS_IDLE` on the advance strobe with no write.
- **wait**: the state is kept in all other cycles.

Top module: `pfx_extender`

## Requirements
- R1: After reset, `rd_data` and `imm_hi` are 0, `src_ext` equals `{1'b0, src_raw}` and `dst_ext` equals `{2'b00, dst_raw}`.
- R2: A cycle with `wr_valid` high stores all 16 bits of `wr_data`, and they appear on `rd_data` from the next cycle on.
- R3: While a prefix is held, `imm_hi` equals bits 7:0 of the stored word.
- R4: While a prefix is held, bit 0 of the stored index is the bank bit of the source. `src_ext` equals `idx[0]*16 + src_raw`.
- R5: While a prefix is held, bits 2:1 of the stored index pick the destination bank. `dst_ext` equals `idx[2:1]*8 + dst_raw`, which gives bases 00h, 08h, 10h and 18h.
- R6: A held prefix persists through any number of cycles without `advance`. The first cycle with `advance` high and `wr_valid` low returns the word and the index to 0 from the following cycle.
- R7: When `wr_valid` and `advance` are high in the same cycle, the newly written word and index are held afterwards. This holds whether or not a prefix was already held.
- R8: All eight index values write the same single 16-bit register, so `rd_data` shows the written word regardless of the index used.
- R9: With no prefix held, `advance` has no effect: the outputs keep the default mapping of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Prefix write strobe |
| wr_index | input | 3 | Bank index carried by the write |
| wr_data | input | 16 | Prefix word carried by the write |
| advance | input | 1 | One instruction retires this cycle |
| src_raw | input | 4 | Raw source register field |
| dst_raw | input | 3 | Raw destination register field |
| rd_data | output | 16 | Currently held prefix word |
| src_ext | output | 5 | Extended source address |
| dst_ext | output | 5 | Extended destination address |
| imm_hi | output | 8 | High byte for the immediate operand |

## Verification
Retirement of the held prefix and loading of a new one can fall on the same edge. This happens when `advance` and `wr_valid` are high together. The bench provokes this overlap from both states. From `PS_ARMED`, it reloads with a different index and word. From `PS_IDLE`, it writes alongside a strobe. In both cases it checks that the new word, bank bits and immediate byte are present in the following cycle, and that a later lone `advance` clears them. All eight indices are swept over every source and destination field, and the expected addresses are computed arithmetically from the index.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_ARMED = 1'b1
    } pfx_state_e;

endpackage

// File: rtl/pfx_hold.sv
module pfx_hold
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              step,
    output logic [DATA_W-1:0] held_word,
    output logic [IDX_W-1:0]  held_idx,
    output logic              armed
);

    pfx_state_e state_q, state_d;
    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              retire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: load, reload, retire, wait
    always_comb begin
        state_d = state_q;
        retire  = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (wr_en) state_d = PS_ARMED;
            end
            PS_ARMED: begin
                if (wr_en) begin
                    state_d = PS_ARMED;
                end else if (step) begin
                    state_d = PS_IDLE;
                    retire  = 1'b1;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // held word and index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (wr_en) begin
            word_q <= wr_word;
            idx_q  <= wr_idx;
        end else if (retire) begin
            word_q <= '0;
            idx_q  <= '0;
        end
    end

    // outputs
    always_comb begin
        held_word = word_q;
        held_idx  = idx_q;
        armed     = (state_q == PS_ARMED);
    end

    // R9: without a held prefix the stored word and index stay at zero
    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (word_q == '0 && idx_q == '0));

endmodule

// File: rtl/pfx_map.sv
module pfx_map #(
    parameter int SRC_W = 4,
    parameter int DST_W = 3,
    parameter int IDX_W = 3,
    parameter int IMM_W = 8,
    localparam int SRC_EXT_W = SRC_W + 1,
    localparam int DST_EXT_W = DST_W + IDX_W - 1
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [IMM_W-1:0]     low_word,
    input  logic [SRC_W-1:0]     src_field,
    input  logic [DST_W-1:0]     dst_field,
    output logic [SRC_EXT_W-1:0] src_addr,
    output logic [DST_EXT_W-1:0] dst_addr,
    output logic [IMM_W-1:0]     imm_byte
);

    // source bank: index bit 0
    always_comb src_addr = {idx[0], src_field};

    // destination bank: the upper index bits
    generate
        if (IDX_W > 1) begin : g_dst_bank
            always_comb dst_addr = {idx[IDX_W-1:1], dst_field};
        end else begin : g_dst_flat
            always_comb dst_addr = dst_field;
        end
    endgenerate

    always_comb imm_byte = low_word;

endmodule

// File: rtl/pfx_extender.sv
module pfx_extender
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int IDX_W  = 3,
    parameter int SRC_W  = 4,
    parameter int DST_W  = 3,
    localparam int SRC_EXT_W = SRC_W + 1,
    localparam int DST_EXT_W = DST_W + IDX_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [IDX_W-1:0]     wr_index,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 advance,
    input  logic [SRC_W-1:0]     src_raw,
    input  logic [DST_W-1:0]     dst_raw,
    output logic [DATA_W-1:0]    rd_data,
    output logic [SRC_EXT_W-1:0] src_ext,
    output logic [DST_EXT_W-1:0] dst_ext,
    output logic [IMM_W-1:0]     imm_hi
);

    logic [DATA_W-1:0] word;
    logic [IDX_W-1:0]  idx;
    logic              armed;

    pfx_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_valid),
        .wr_idx    (wr_index),
        .wr_word   (wr_data),
        .step      (advance),
        .held_word (word),
        .held_idx  (idx),
        .armed     (armed)
    );

    pfx_map #(
        .SRC_W(SRC_W), .DST_W(DST_W), .IDX_W(IDX_W), .IMM_W(IMM_W)
    ) u_map (
        .idx       (idx),
        .low_word  (word[IMM_W-1:0]),
        .src_field (src_raw),
        .dst_field (dst_raw),
        .src_addr  (src_ext),
        .dst_addr  (dst_ext),
        .imm_byte  (imm_hi)
    );

    always_comb rd_data = word;

    // R2: a write lands in the readable register one cycle later
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (rd_data == $past(wr_data)));

    // R6: a lone advance strobe with a held prefix restores defaults
    assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && advance && !wr_valid) |=> (rd_data == '0 && imm_hi == '0 && !armed));

    // R6: with no write and no advance the held word is unchanged
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !advance) |=> $stable(rd_data));

    // R7: on a collision the new index drives the source bank bit
    assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && advance) |=> (armed && src_ext[SRC_EXT_W-1] == $past(wr_index[0])));

    // R3: the immediate byte tracks the low byte of the held word
    assert_imm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        imm_hi == rd_data[IMM_W-1:0]);

endmodule

// File: tb/pfx_extender_test.sv
`timescale 1ns/1ps
module pfx_extender_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_index = '0;
    logic [15:0] wr_data = '0;
    logic        advance = 1'b0;
    logic [3:0]  src_raw = '0;
    logic [2:0]  dst_raw = '0;
    logic [15:0] rd_data;
    logic [4:0]  src_ext;
    logic [4:0]  dst_ext;
    logic [7:0]  imm_hi;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pfx_extender uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_data(wr_data), .advance(advance), .src_raw(src_raw), .dst_raw(dst_raw),
        .rd_data(rd_data), .src_ext(src_ext), .dst_ext(dst_ext), .imm_hi(imm_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // check all outputs for a held (or default) index and word
    task automatic chk_map(input string req, input int idx, input int word);
        chk({req, " rd"}, int'(rd_data), word);
        chk({req, " imm"}, int'(imm_hi), word % 256);
        chk({req, " src"}, int'(src_ext), (idx % 2) * 16 + int'(src_raw));
        chk({req, " dst"}, int'(dst_ext), (idx / 2) * 8 + int'(dst_raw));
    endtask

    task automatic write(input int idx, input int word, input logic with_adv);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_index = idx[2:0];
        wr_data  = word[15:0];
        advance  = with_adv;
        @(negedge clk);
        wr_valid = 1'b0;
        advance  = 1'b0;
    endtask

    task automatic step_once();
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        src_raw = 4'hA; dst_raw = 3'h5; #0.1;
        chk_map("R1 reset", 0, 0);

        // R9: advance with nothing held
        step_once();
        chk_map("R9 idle advance", 0, 0);

        // R4 R5 R3 R8: sweep indices and fields, held across many cycles (R6)
        for (int i = 0; i < 8; i++) begin
            int w;
            w = 16'h5A00 + i * 37 + i * 4096;
            write(i, w, 1'b0);
            chk("R2 load", int'(rd_data), w);
            chk("R8 same register", int'(rd_data), w);
            for (int s = 0; s < 16; s++) begin
                for (int d = 0; d < 8; d++) begin
                    src_raw = s[3:0]; dst_raw = d[2:0];
                    #1;
                    chk_map("R4 R5 R3 sweep", i, w);
                end
            end
            chk("R6 persists", int'(rd_data), w);
            step_once();
            chk_map("R6 retire", 0, 0);
        end

        // R7: reload colliding with retire, from armed
        write(1, 16'h1234, 1'b0);
        write(6, 16'hBEEF, 1'b1);
        src_raw = 4'h3; dst_raw = 3'h7; #0.1;
        chk_map("R7 collide armed", 6, 16'hBEEF);
        step_once();
        chk_map("R7 after retire", 0, 0);

        // R7: write with advance from idle
        write(5, 16'h00C3, 1'b1);
        chk_map("R7 collide idle", 5, 16'h00C3);
        step_once();
        chk_map("R6 clear again", 0, 0);

        // R1: reset clears a held prefix
        write(7, 16'hFFFF, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #0.1;
        chk_map("R1 reset clears", 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule